// File: doc/BRIEF.md
# Oversampled Serial Receiver with Noise Detection

This block receives asynchronous serial characters on a single input line. An external enable pulse marks sixteen sample instants per bit period. The receiver finds a falling edge and confirms the start bit. It then collects eight or nine data bits, least significant bit first, and checks the stop bit. When a character completes, it is copied from the shift register into a holding register and a data-ready flag is raised.

Each bit is judged from three samples taken in the middle of the bit period. If the three samples disagree, the character is flagged as noisy. A start bit whose majority reads high is treated as a spurious edge: the frame is dropped and nothing is delivered. If that start bit was also noisy, a latent noise indication is kept and appears with the next good character. Software acknowledges a character by a status read followed by a data read. A character that completes while the previous one is still unread raises overrun and leaves the held data as it was.

Top module: `uart_rx_nf`

## Requirements
- R1: With `nine_bit` low, a frame is one low start bit, 8 data bits sent LSB first and one high stop bit. When the frame ends, the data appears on `rx_data` and `data_ready` rises.
- R2: With `nine_bit` high, there are 9 data bits. The lower eight go to `rx_data` and the ninth goes to `bit8`. With `nine_bit` low, `bit8` reads 0.
- R3: Each bit is sampled at ticks 8, 9 and 10 of its period (tick 0 is the tick at which the falling edge is seen) and decided by majority vote. If any bit's three samples disagree, the character is still delivered, and `noise` rises together with `data_ready`.
- R4: If the start bit's majority vote is high, the frame is discarded and `data_ready` does not rise. If its samples were mixed (011, 101 or 110), a hidden noise indication is stored. `noise` then shows 1 with the next delivered character.
- R5: If a character completes while `data_ready` is still set, `overrun` rises and `rx_data` keeps the earlier character.
- R6: A pulse on `status_rd` followed later by a pulse on `data_rd` clears `data_ready`, `overrun`, `noise`, `frame_err` and `idle_flag`. A `data_rd` without a preceding `status_rd` clears nothing.
- R7: A stop bit whose majority vote is low sets `frame_err` with the delivered character. A break (all-zero frame) is reported this way.
- R8: While the receiver is waiting for a start bit, a run of high samples lasting one character time sets `idle_flag`. In 8-bit mode this is 160 ticks; in 9-bit mode it is 176 ticks. It fires only once, and the next start bit re-arms it.
- R9: `irq` = `gie` & ((`rie` & (`data_ready` | `overrun`)) | (`idle_ie` & `idle_flag`)). Noise alone never drives it.
- R10: While `rx_en` is low, line activity is ignored: no character is delivered and no idle run is counted.
- R11: After reset all flags, `irq` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rie | input | 1 | Receive/overrun interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| gie | input | 1 | Global interrupt enable |
| status_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | 8 | Received data (lower eight bits) |
| bit8 | output | 1 | Ninth data bit in 9-bit mode |
| data_ready | output | 1 | Character available |
| overrun | output | 1 | Character lost while buffer full |
| noise | output | 1 | Sample disagreement seen |
| frame_err | output | 1 | Stop bit read low |
| idle_flag | output | 1 | Idle line detected |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or sample-phase counter shows up on `rx_data` or `frame_err` for the very frame it affects, because a misplaced sample window shifts bits or reads the stop bit from data. A wrong hidden-noise or clear-handshake state stays invisible until the following character or the following read strobe. The directed scenarios therefore always follow a disturbance with one more clean frame or one more read. A stuck idle counter is caught by checking the flag both just before and just after the character-time boundary.

// File: rtl/uart_rx_nf.sv
module uart_rx_nf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       rie,
  input  logic       idle_ie,
  input  logic       gie,
  input  logic       status_rd,
  input  logic       data_rd,
  output logic [7:0] rx_data,
  output logic       bit8,
  output logic       data_ready,
  output logic       overrun,
  output logic       noise,
  output logic       frame_err,
  output logic       idle_flag,
  output logic       irq
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t        st;
  logic [1:0] sync;
  logic       line_q;
  logic [3:0] cnt;
  logic [2:0] smp;
  logic [3:0] bidx;
  logic [8:0] shreg;
  logic [7:0] idle_cnt;
  logic       fnoise, hidden_nf, clr_armed, idle_armed;

  wire       line     = sync[1];
  wire       vote     = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  wire       split    = (smp != 3'b000) && (smp != 3'b111);
  wire       last_bit = bidx == (nine_bit ? 4'd8 : 4'd7);
  wire       clr_now  = data_rd & clr_armed;
  wire [7:0] idle_lim = nine_bit ? 8'd176 : 8'd160;

  assign irq = gie & ((rie & (data_ready | overrun)) | (idle_ie & idle_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  sync <= 2'b11;  line_q <= 1'b1;  cnt <= '0;  smp <= '0;
      bidx <= '0;  shreg <= '0;  idle_cnt <= '0;  fnoise <= 1'b0;
      hidden_nf <= 1'b0;  clr_armed <= 1'b0;  idle_armed <= 1'b1;
      rx_data <= '0;  bit8 <= 1'b0;  data_ready <= 1'b0;  overrun <= 1'b0;
      noise <= 1'b0;  frame_err <= 1'b0;  idle_flag <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      if (status_rd)    clr_armed <= 1'b1;
      else if (data_rd) clr_armed <= 1'b0;
      if (clr_now) begin
        data_ready <= 1'b0;  overrun <= 1'b0;  noise <= 1'b0;
        frame_err <= 1'b0;   idle_flag <= 1'b0;
      end
      if (tick) line_q <= line;
      if (!rx_en) begin
        st <= S_IDLE;
        idle_cnt <= '0;
      end else if (tick) begin
        if (cnt == 4'd8 || cnt == 4'd9 || cnt == 4'd10) smp <= {smp[1:0], line};
        if (st == S_IDLE) begin
          cnt <= 4'd1;  bidx <= '0;  fnoise <= 1'b0;
          if (line_q && !line) begin
            st <= S_START;  idle_armed <= 1'b1;  idle_cnt <= '0;
          end else if (!line || !idle_armed) begin
            idle_cnt <= '0;
          end else if (idle_cnt == idle_lim - 8'd1) begin
            idle_flag <= 1'b1;  idle_armed <= 1'b0;  idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_cnt + 8'd1;
          end
        end else begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) begin
            case (st)
              S_START: begin
                if (vote) begin
                  st <= S_IDLE;
                  if (split) hidden_nf <= 1'b1;
                end else begin
                  st <= S_DATA;
                  fnoise <= split;
                end
              end
              S_DATA: begin
                shreg[bidx] <= vote;
                fnoise <= fnoise | split;
                bidx <= bidx + 4'd1;
                if (last_bit) st <= S_STOP;
              end
              default: begin
                st <= S_IDLE;
                if (data_ready && !clr_now) begin
                  overrun <= 1'b1;
                end else begin
                  rx_data    <= shreg[7:0];
                  bit8       <= nine_bit & shreg[8];
                  data_ready <= 1'b1;
                  noise      <= fnoise | split | hidden_nf;
                  frame_err  <= !vote;
                  hidden_nf  <= 1'b0;
                end
              end
            endcase
          end
        end
      end
    end
  end

  // R5
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(rx_data));
  // R6
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(data_rd));
  // R3
  noise_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noise |-> data_ready);
  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> st == S_IDLE);
  // R1
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(tick));
endmodule

// File: tb/uart_rx_nf_test.sv
module uart_rx_nf_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1, rx_en = 1'b1, nine_bit = 1'b0;
  logic rie = 1'b1, idle_ie = 1'b0, gie = 1'b1, status_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rx_data;
  logic bit8, data_ready, overrun, noise, frame_err, idle_flag, irq;
  logic [1:0] tdiv = '0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  uart_rx_nf uut (.clk, .rst_n, .tick, .rxd, .rx_en, .nine_bit, .rie, .idle_ie, .gie,
                  .status_rd, .data_rd, .rx_data, .bit8, .data_ready, .overrun, .noise,
                  .frame_err, .idle_flag, .irq);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = v;
      @(posedge clk iff tick);
      @(negedge clk);
    end
  endtask

  task automatic align;
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic stopv, input int noisy, input logic [2:0] sp);
    int nb;
    nb = nine_bit ? 9 : 8;
    align;
    put(0, 8); put(sp[2], 1); put(sp[1], 1); put(sp[0], 1); put(0, 5);
    for (int b = 0; b < nb; b++) begin
      if (b == noisy) begin put(d[b], 9); put(~d[b], 1); put(d[b], 6); end
      else put(d[b], 16);
    end
    put(stopv, 16);
    rxd = 1'b1;
  endtask

  task automatic clear_flags;
    @(negedge clk) status_rd = 1'b1;
    @(negedge clk) begin status_rd = 1'b0; data_rd = 1'b1; end
    @(negedge clk) data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 data_ready", data_ready, 0);  chk("R11 overrun", overrun, 0);
    chk("R11 noise", noise, 0);            chk("R11 frame_err", frame_err, 0);
    chk("R11 idle", idle_flag, 0);         chk("R11 irq", irq, 0);
    chk("R11 rx_data", rx_data, 0);
  endtask

  task automatic t_idle_reset;
    idle_ie = 1'b1;
    put(1, 140);
    chk("R8 idle early", idle_flag, 0);
    put(1, 30);
    chk("R8 idle set", idle_flag, 1);
    chk("R9 idle irq", irq, 1);
    clear_flags;
    chk("R6 idle cleared", idle_flag, 0);
    idle_ie = 1'b0;
  endtask

  task automatic t_basic;
    send(9'h0A5, 1, -1, 3'b000);
    chk("R1 data", rx_data, 8'hA5);  chk("R1 ready", data_ready, 1);
    chk("R1 noise", noise, 0);       chk("R7 no fe", frame_err, 0);
    chk("R2 bit8 8-bit", bit8, 0);   chk("R9 irq rie", irq, 1);
    gie = 1'b0; #1;
    chk("R9 irq gated", irq, 0);
    gie = 1'b1;
    clear_flags;
    chk("R6 ready clear", data_ready, 0);  chk("R9 irq low", irq, 0);
  endtask

  task automatic t_handshake;
    send(9'h03C, 1, -1, 3'b000);
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
    @(negedge clk);
    chk("R6 data read alone", data_ready, 1);
    @(negedge clk) status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 status alone", data_ready, 1);
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
    chk("R6 sequence clears", data_ready, 0);
  endtask

  task automatic t_nine;
    nine_bit = 1'b1;
    send(9'h1A5, 1, -1, 3'b000);
    chk("R2 low byte", rx_data, 8'hA5);  chk("R2 bit8 set", bit8, 1);
    clear_flags;
    send(9'h0FF, 1, -1, 3'b000);
    chk("R2 low byte ff", rx_data, 8'hFF);  chk("R2 bit8 clear", bit8, 0);
    clear_flags;
    nine_bit = 1'b0;
  endtask

  task automatic t_noise;
    send(9'h05A, 1, 3, 3'b000);
    chk("R3 data kept", rx_data, 8'h5A);  chk("R3 ready", data_ready, 1);
    chk("R3 noise", noise, 1);
    clear_flags;
    chk("R3 noise cleared", noise, 0);
  endtask

  task automatic t_false_start;
    align;
    put(0, 8); put(0, 1); put(1, 1); put(1, 1); put(0, 5);
    put(1, 32);
    chk("R4 discarded", data_ready, 0);  chk("R4 hidden", noise, 0);
    send(9'h03C, 1, -1, 3'b000);
    chk("R4 next data", rx_data, 8'h3C);  chk("R4 noise shown", noise, 1);
    clear_flags;
  endtask

  task automatic t_overrun;
    send(9'h011, 1, -1, 3'b000);
    send(9'h022, 1, -1, 3'b000);
    chk("R5 overrun", overrun, 1);  chk("R5 old data", rx_data, 8'h11);
    chk("R9 irq overrun", irq, 1);
    clear_flags;
    chk("R6 overrun clear", overrun, 0);
    send(9'h033, 1, -1, 3'b000);
    chk("R5 fresh data", rx_data, 8'h33);  chk("R5 no overrun", overrun, 0);
    clear_flags;
  endtask

  task automatic t_frame;
    send(9'h081, 0, -1, 3'b000);
    chk("R7 fe", frame_err, 1);  chk("R7 data", rx_data, 8'h81);
    clear_flags;
    put(1, 4);
    send(9'h000, 0, -1, 3'b000);
    chk("R7 break fe", frame_err, 1);  chk("R7 break data", rx_data, 0);
    clear_flags;
    put(1, 4);
  endtask

  task automatic t_idle_frame;
    idle_ie = 1'b1;
    send(9'h044, 1, -1, 3'b000);
    clear_flags;
    put(1, 145);
    chk("R8 not yet", idle_flag, 0);
    put(1, 25);
    chk("R8 after frame", idle_flag, 1);
    clear_flags;
    put(1, 200);
    chk("R8 once", idle_flag, 0);
    idle_ie = 1'b0;
  endtask

  task automatic t_disable;
    rx_en = 1'b0;
    send(9'h055, 1, -1, 3'b000);
    put(1, 4);
    chk("R10 ignored", data_ready, 0);
    rx_en = 1'b1;
    put(1, 4);
    send(9'h066, 1, -1, 3'b000);
    chk("R10 enabled", rx_data, 8'h66);
    clear_flags;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_idle_reset;
    t_basic;
    t_handshake;
    t_nine;
    t_noise;
    t_false_start;
    t_overrun;
    t_frame;
    t_idle_frame;
    t_disable;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule